// File: doc/BRIEF.md
# Debounced Input Pin Request Decoder

This block handles one general-purpose pin of a power-management controller while that pin is configured as an input. A direction bit enables input handling. A polarity bit selects which raw level counts as active. A four-bit function code selects two things: how long the pin must settle before a change is believed, and what each settled edge means. Depending on the code, the block either reports the filtered level only, or turns filtered edges into single-cycle request strobes for power-on, power-off, sleep, wake and watchdog restart.

The raw pin passes through a two-flop synchronizer. The polarity bit is then applied, and the result goes to a debounce filter. The filter runs from one of three free-running sampling ticks, whose periods in system-clock cycles are parameters. A change is accepted only when the input differs from the filtered state on two consecutive ticks. The settling time therefore lies between one and two tick periods. After reset the filtered state is loaded directly from the first valid synchronized sample, so no request is raised at power-up whatever the pin level is.

Top module: `gpin_req_unit`

## Requirements
- R1: While `dir_i` is 0 (output mode), every request output stays 0 for every function code and every pin activity.
- R2: Codes 0, 1 and 2 are level-only functions using the short, medium and long windows. They raise no request, and `level_o` follows the filtered active level.
- R3: A pin change shows on `level_o` and on the request outputs no earlier than one tick period and no later than two tick periods plus four cycles after it reaches the pin. A pulse that lasts less than one tick period is rejected. Windows are `SHORT_TICK`, `MID_TICK` or `LONG_TICK` cycles.
- R4: Codes 3 (short window) and 4 (long window) map an active-going edge to `on_req_o` and an inactive-going edge to `off_req_o`.
- R5: Code 5 (short window) maps an active-going edge to `sleep_req_o` and an inactive-going edge to `wake_req_o`.
- R6: Code 6 (short) raises `sleep_req_o` and code 7 (short) raises `on_req_o`, both on active-going edges only. Inactive-going edges raise nothing.
- R7: Code 8 (short) raises `wdog_kick_o` on an active-going edge only.
- R8: With `pol_i` = 1 a high pin is active. With `pol_i` = 0 the pin is inverted before filtering, so the two edge roles swap and `level_o` reports the inverted level.
- R9: Codes 9 to 15 raise no request and filter the level with the long window.
- R10: Each accepted edge gives exactly one request strobe, one clock wide, and at most one request output is high in any cycle.
- R11: During reset and after it, all request outputs are 0. After reset the filtered state is loaded from the pin without raising a request, so an active pin held through reset gives `level_o` = 1 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Raw, asynchronous pin level |
| dir_i | input | 1 | 1 = input mode, 0 = output mode (requests held off) |
| pol_i | input | 1 | 1 = high is active, 0 = low is active |
| fn_i | input | 4 | Function code selecting window and edge meaning |
| level_o | output | 1 | Filtered active level |
| on_req_o | output | 1 | Power-on request strobe |
| off_req_o | output | 1 | Power-off request strobe |
| sleep_req_o | output | 1 | Sleep request strobe |
| wake_req_o | output | 1 | Wake request strobe |
| wdog_kick_o | output | 1 | Watchdog restart strobe |

## Verification
A pin change needs two cycles to cross the synchronizer. After that, the filter must see the changed value on two successive ticks, and the strobe is registered on the edge where the change is accepted. A result is therefore due between one tick period and two tick periods plus about four cycles after the stimulus. The exact cycle depends on the free-running tick phase, so the bench does not sample at one fixed edge. It counts strobes on every output across a window of two periods plus eight cycles, checks that the first strobe came no sooner than one period, and reads `level_o` at the end of the window. The glitch and power-up cases use windows of the same length, in which every strobe count must stay zero.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

  typedef enum logic [1:0] {
    WIN_SHORT = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LONG  = 2'd2
  } gpin_win_e;

  localparam int unsigned NUM_WIN = 3;

  // Function codes; values 9..15 are undefined (level only, long window)
  localparam logic [3:0] FN_LVL_S   = 4'd0;
  localparam logic [3:0] FN_LVL_M   = 4'd1;
  localparam logic [3:0] FN_LVL_L   = 4'd2;
  localparam logic [3:0] FN_ONOFF_S = 4'd3;
  localparam logic [3:0] FN_ONOFF_L = 4'd4;
  localparam logic [3:0] FN_SLPWAKE = 4'd5;
  localparam logic [3:0] FN_SLP     = 4'd6;
  localparam logic [3:0] FN_ON      = 4'd7;
  localparam logic [3:0] FN_WDOG    = 4'd8;

  typedef struct packed {
    logic on;
    logic off;
    logic sleep;
    logic wake;
    logic kick;
  } gpin_req_t;

  function automatic gpin_win_e win_of(input logic [3:0] fn);
    gpin_win_e w;
    case (fn)
      FN_LVL_M:                       w = WIN_MID;
      FN_LVL_L, FN_ONOFF_L:           w = WIN_LONG;
      FN_LVL_S, FN_ONOFF_S, FN_SLPWAKE,
      FN_SLP, FN_ON, FN_WDOG:         w = WIN_SHORT;
      default:                        w = WIN_LONG;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/gpin_rst_sync.sv
module gpin_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/gpin_sync.sv
module gpin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpin_tick_div.sv
module gpin_tick_div #(
  parameter int unsigned PERIOD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gpin_debounce.sv
module gpin_debounce #(
  parameter int unsigned WARM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic tick_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o,
  output logic primed_o
);
  localparam int unsigned WW = $clog2(WARM + 1);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARM);

  logic          filt_q, filt_d;
  logic          agree_q, agree_d;
  logic          primed_q, primed_d;
  logic [WW-1:0] warm_q, warm_d;
  logic          filt_en;

  always_comb begin
    filt_d   = filt_q;
    agree_d  = agree_q;
    primed_d = primed_q;
    warm_d   = warm_q;
    rise_o   = 1'b0;
    fall_o   = 1'b0;
    filt_en  = 1'b0;
    if (!primed_q) begin
      if (warm_q == WARM_LAST) begin
        filt_en  = 1'b1;
        filt_d   = din_i;
        primed_d = 1'b1;
      end else begin
        warm_d = warm_q + 1'b1;
      end
    end else if (tick_i) begin
      if (din_i != filt_q) begin
        if (agree_q) begin
          filt_en = 1'b1;
          filt_d  = din_i;
          agree_d = 1'b0;
          rise_o  = din_i;
          fall_o  = ~din_i;
        end else begin
          agree_d = 1'b1;
        end
      end else begin
        agree_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q   <= 1'b0;
      agree_q  <= 1'b0;
      primed_q <= 1'b0;
      warm_q   <= '0;
    end else begin
      if (filt_en) filt_q <= filt_d;
      agree_q  <= agree_d;
      primed_q <= primed_d;
      warm_q   <= warm_d;
    end
  end

  assign level_o  = filt_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/gpin_req_map.sv
module gpin_req_map
  import gpin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic [3:0] fn_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output gpin_req_t  req_o
);
  gpin_req_t req_q, req_d;

  always_comb begin
    req_d = '0;
    if (dir_i) begin
      case (fn_i)
        FN_ONOFF_S, FN_ONOFF_L: begin
          req_d.on  = rise_i;
          req_d.off = fall_i;
        end
        FN_SLPWAKE: begin
          req_d.sleep = rise_i;
          req_d.wake  = fall_i;
        end
        FN_SLP:  req_d.sleep = rise_i;
        FN_ON:   req_d.on    = rise_i;
        FN_WDOG: req_d.kick  = rise_i;
        default: req_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/gpin_req_unit.sv
module gpin_req_unit
  import gpin_pkg::*;
#(
  parameter int unsigned SHORT_TICK  = 1600,
  parameter int unsigned MID_TICK    = 200000,
  parameter int unsigned LONG_TICK   = 1600000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       dir_i,
  input  logic       pol_i,
  input  logic [3:0] fn_i,
  output logic       level_o,
  output logic       on_req_o,
  output logic       off_req_o,
  output logic       sleep_req_o,
  output logic       wake_req_o,
  output logic       wdog_kick_o
);
  logic              rst_sync_n;
  logic              pin_sync;
  logic              pin_act;
  logic [NUM_WIN-1:0] tick_w;
  logic              tick_sel;
  logic              rise, fall, primed;
  gpin_req_t         req_q;

  gpin_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  gpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign pin_act = pol_i ? pin_sync : ~pin_sync;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_tick
    localparam int unsigned PER = (w == 0) ? SHORT_TICK :
                                  (w == 1) ? MID_TICK : LONG_TICK;
    gpin_tick_div #(.PERIOD(PER)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .tick_o(tick_w[w])
    );
  end

  always_comb begin
    case (win_of(fn_i))
      WIN_SHORT: tick_sel = tick_w[0];
      WIN_MID:   tick_sel = tick_w[1];
      default:   tick_sel = tick_w[2];
    endcase
  end

  gpin_debounce #(.WARM(SYNC_STAGES)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .din_i   (pin_act),
    .tick_i  (tick_sel),
    .level_o (level_o),
    .rise_o  (rise),
    .fall_o  (fall),
    .primed_o(primed)
  );

  gpin_req_map u_map (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .dir_i (dir_i),
    .fn_i  (fn_i),
    .rise_i(rise),
    .fall_i(fall),
    .req_o (req_q)
  );

  assign on_req_o    = req_q.on;
  assign off_req_o   = req_q.off;
  assign sleep_req_o = req_q.sleep;
  assign wake_req_o  = req_q.wake;
  assign wdog_kick_o = req_q.kick;
endmodule

// File: rtl/gpin_req_unit_chk.sv
module gpin_req_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dir_i,
  input logic [3:0] fn_i,
  input logic       level_i,
  input logic [4:0] req_i,
  input logic       tick_i,
  input logic       primed_i
);
  // req_i bit order: on, off, sleep, wake, kick (MSB first)

  a_r1_output_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i |=> (req_i == 5'b0));

  a_r2_level_codes_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i <= 4'd2) |=> (req_i == 5'b0));

  a_r9_undefined_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i >= 4'd9) |=> (req_i == 5'b0));

  a_r3_level_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(primed_i) && !$stable(level_i)) |-> $past(tick_i));

  a_r5_wake_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[1] |-> ($past(fn_i) == 4'd5 && $past(dir_i)));

  a_r6_sleep_only_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == 4'd6) |=> (req_i[4] == 1'b0 && req_i[3] == 1'b0 && req_i[1] == 1'b0));

  a_r7_kick_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> ($past(fn_i) == 4'd8 && $past(dir_i)));

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_i));

  a_r10_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != 5'b0) |=> (req_i == 5'b0));

  a_r11_no_request_before_primed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |-> (req_i == 5'b0));
endmodule

bind gpin_req_unit gpin_req_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .dir_i   (dir_i),
  .fn_i    (fn_i),
  .level_i (level_o),
  .req_i   (req_q),
  .tick_i  (tick_sel),
  .primed_i(primed)
);

// File: tb/tb_gpin_req_unit.sv
`timescale 1ns/1ps
module tb_gpin_req_unit;
  localparam int SHORT = 4;
  localparam int MID   = 6;
  localparam int LONG  = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, dir, pol;
  logic [3:0] fn;
  logic       level, on_r, off_r, slp_r, wk_r, kick_r;

  int  n_chk = 0;
  int  n_err = 0;
  int  cyc = 0;
  bit  counting = 0;
  int  cnt [5];
  int  first_at;
  int  start_cyc;

  always #10 clk = ~clk;

  gpin_req_unit #(.SHORT_TICK(SHORT), .MID_TICK(MID), .LONG_TICK(LONG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_i(dir), .pol_i(pol), .fn_i(fn),
    .level_o(level), .on_req_o(on_r), .off_req_o(off_r), .sleep_req_o(slp_r),
    .wake_req_o(wk_r), .wdog_kick_o(kick_r)
  );

  wire [4:0] req_vec = {on_r, off_r, slp_r, wk_r, kick_r};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (counting) begin
      for (int k = 0; k < 5; k++) if (req_vec[4-k]) cnt[k] = cnt[k] + 1;
      if (req_vec != 5'b0 && first_at < 0) first_at = cyc - start_cyc;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int per_of(input logic [3:0] f);
    if (f == 4'd1) return MID;
    if (f == 4'd2 || f == 4'd4 || f >= 4'd9) return LONG;
    return SHORT;
  endfunction

  // Expected strobes {on,off,sleep,wake,kick} for an accepted edge
  function automatic logic [4:0] exp_req(input logic [3:0] f, input logic d, input logic rise);
    if (!d) return 5'b0;
    case (f)
      4'd3, 4'd4: return rise ? 5'b10000 : 5'b01000;
      4'd5:       return rise ? 5'b00100 : 5'b00010;
      4'd6:       return rise ? 5'b00100 : 5'b00000;
      4'd7:       return rise ? 5'b10000 : 5'b00000;
      4'd8:       return rise ? 5'b00001 : 5'b00000;
      default:    return 5'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] f, input logic d, input logic p);
    string t;
    if (!d)             t = "R1";
    else if (f <= 4'd2) t = "R2";
    else if (f <= 4'd4) t = "R4";
    else if (f == 4'd5) t = "R5";
    else if (f <= 4'd7) t = "R6";
    else if (f == 4'd8) t = "R7";
    else                t = "R9";
    if (!p) t = {t, "/R8"};
    return t;
  endfunction

  task automatic do_reset(input logic raw_pin);
    @(negedge clk); #1;
    pin = raw_pin;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_vec == 5'b0, "R11 strobes in reset", int'(req_vec), 0);
    #1 rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic arm();
    for (int k = 0; k < 5; k++) cnt[k] = 0;
    first_at = -1;
    start_cyc = cyc;
    counting = 1;
  endtask

  // Drive the pin to an active level, watch the window, compare
  task automatic edge_check(input logic active, input string tg);
    int p = per_of(fn);
    logic [4:0] e = exp_req(fn, dir, active);
    @(negedge clk); #1;
    arm();
    pin = pol ? active : ~active;
    repeat (2 * p + 8) @(negedge clk);
    #1 counting = 0;
    for (int k = 0; k < 5; k++)
      chk(cnt[k] == int'(e[4-k]), {tg, "/R10 strobe count"}, cnt[k], int'(e[4-k]));
    if (e != 5'b0) chk(first_at >= p, {tg, "/R3 earliest strobe"}, first_at, p);
    chk(level == active, {tg, "/R3 level"}, int'(level), int'(active));
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; dir = 1'b1; pol = 1'b1; fn = 4'd0;
    chk(1'b1, "R11 start", 0, 0);

    // Sweep every code and both polarities in input mode
    for (int f = 0; f < 16; f++) begin
      for (int pl = 0; pl < 2; pl++) begin
        dir = 1'b1; pol = pl[0]; fn = f[3:0];
        do_reset(~pol);
        chk(level == 1'b0, "R11 level after reset", int'(level), 0);
        edge_check(1'b1, tag_of(fn, dir, pol));
        edge_check(1'b0, tag_of(fn, dir, pol));
      end
    end

    // Output mode: no strobes for any requesting code
    for (int f = 3; f < 9; f++) begin
      dir = 1'b0; pol = 1'b1; fn = f[3:0];
      do_reset(1'b0);
      edge_check(1'b1, "R1");
      edge_check(1'b0, "R1");
    end

    // Glitches shorter than one tick period are rejected
    dir = 1'b1; pol = 1'b1;
    for (int f = 3; f < 5; f++) begin
      fn = f[3:0];
      do_reset(1'b0);
      @(negedge clk); #1;
      arm();
      pin = 1'b1;
      repeat (per_of(fn) - 1) @(negedge clk);
      #1 pin = 1'b0;
      repeat (2 * LONG + 8) @(negedge clk);
      #1 counting = 0;
      chk(cnt[0] + cnt[1] == 0, "R3 glitch rejected", cnt[0] + cnt[1], 0);
      chk(level == 1'b0, "R3 glitch level", int'(level), 0);
    end

    // Active pin held through reset: level loads, no strobe
    for (int pl = 0; pl < 2; pl++) begin
      pol = pl[0]; fn = 4'd3;
      @(negedge clk); #1;
      arm();
      do_reset(pol);
      repeat (2 * SHORT + 8) @(negedge clk);
      #1 counting = 0;
      chk(cnt[0] + cnt[1] == 0, "R11 no power-up strobe", cnt[0] + cnt[1], 0);
      chk(level == 1'b1, "R11 level loaded", int'(level), 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule